// File: doc/BRIEF.md
# OSD Display Memory Write Command Parser

This block sits behind a serial-bus slave receiver that has already matched its device address. It takes the received bytes one at a time, together with frame-start and frame-stop markers, and converts them into single write transactions for an on-screen-display memory. There are two target areas. The character area holds 15 rows of 30 character codes. The attribute/control area spans rows 0 to 16 with up to 32 columns.

Each byte is either a row header, a column header or a data byte, depending on the parser's position in the stream and on the byte's upper bits. Two addressed formats are supported. In the first, every data byte carries its own row and column header. In the second, the row is kept and each data byte carries only a column header. A third format is a burst: after a single row and column header, every byte is data and the location advances by itself. At the end of each row, padding positions are consumed without a write.

Once a burst has started, the parser stays in burst mode until the next frame marker. Positions that fall outside an area are never written. Each accepted data byte yields at most one registered write strobe, and that strobe carries the area, row, column and data together.

Top module: `osd_wr_parser`

## Requirements
- R1: While reset is asserted and on the first cycle after release, `wr_en` is low and the `wr_area`, `wr_row`, `wr_col` and `wr_data` fields are zero.
- R2: When a row header is expected, a byte with bits [7:5] = 100 selects the character area (`wr_area` = 0) and a byte with bits [7:5] = 101 selects the attribute area (`wr_area` = 1). Bits [4:0] give the row. Any other byte arriving while a row header is expected is ignored and changes nothing.
- R3: When a column header is expected, a byte with bit 7 = 0 is a column header: bits [4:0] give the column, bit 6 = 0 selects addressed mode and bit 6 = 1 starts a burst. A byte with bit 7 = 1 at that point is re-read as a row header.
- R4: In addressed mode, the sequence row, column, data writes the data byte once, to that row and column. A following byte with bit 7 = 1 begins a new row header.
- R5: After a data byte in addressed mode, a byte with bit 7 = 0 is a new column header for the same row and area. The next data byte is written there.
- R6: In a burst, every byte is data. It is written at the current location, the column then advances by one, and after column 31 the column returns to 0 and the row advances by one.
- R7: In a character-area burst, the bytes that land on columns 30 and 31 are consumed without a write.
- R8: In an attribute-area burst, the byte on column 30 is written and the byte on column 31 is consumed without a write.
- R9: In a burst, a byte with bit 7 set is still data. Only a frame marker ends the burst.
- R10: A frame-start or frame-stop marker returns the parser to expecting a row header. A byte presented in the same cycle as a marker is dropped.
- R11: In addressed mode, writes to character rows above 14, character columns above 29, or attribute rows above 16 are suppressed.
- R12: A write appears on the outputs exactly one cycle after the data byte is accepted, as a one-cycle `wr_en` pulse per written byte. The area, row, column and data are valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | A received byte is present this cycle |
| byte_data | input | 8 | Received byte |
| frm_start | input | 1 | Start marker of a bus transfer |
| frm_stop | input | 1 | Stop marker of a bus transfer |
| wr_en | output | 1 | One-cycle write strobe |
| wr_area | output | 1 | 0 = character area, 1 = attribute/control area |
| wr_row | output | 5 | Write row |
| wr_col | output | 5 | Write column |
| wr_data | output | 8 | Write data |

## Verification
Every result of this block is due exactly one clock after the byte or marker that causes it, because one output register separates the decode from the ports. The bench therefore presents each byte on a falling edge and samples all five outputs one time unit after the following rising edge. It compares them there with a location that it tracks arithmetically for each format. Sweeps cover every row and column code of both areas in addressed mode and complete multi-row bursts in each area, so each suppressed position and each padding position is checked in its own cycle.

// File: rtl/osd_wr_pkg.sv
package osd_wr_pkg;

  // Row header codes in the top three bits of a header byte
  localparam logic [2:0] HDR_CHAR = 3'b100;
  localparam logic [2:0] HDR_ATTR = 3'b101;

  typedef enum logic {
    AREA_CHAR = 1'b0,
    AREA_ATTR = 1'b1
  } area_e;

  typedef enum logic [2:0] {
    ST_ROW   = 3'd0,  // expecting a row header
    ST_COL   = 3'd1,  // expecting a column header
    ST_DATA  = 3'd2,  // expecting one addressed data byte
    ST_NEXT  = 3'd3,  // after addressed data: row or column header
    ST_BURST = 3'd4   // every byte is data, address auto-advances
  } pstate_e;

endpackage

// File: rtl/osd_byte_decode.sv
module osd_byte_decode
  import osd_wr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ROW_W  = 5,
  parameter int COL_W  = 5
) (
  input  logic [DATA_W-1:0] byte_i,
  output logic              top_set,
  output logic              hdr_hit,
  output area_e             hdr_area,
  output logic [ROW_W-1:0]  hdr_row,
  output logic              col_burst,
  output logic [COL_W-1:0]  col_num
);

  localparam int TOP = DATA_W - 1;

  logic [2:0] top3;

  always_comb begin
    top3      = byte_i[TOP -: 3];
    top_set   = byte_i[TOP];
    hdr_hit   = (top3 == HDR_CHAR) || (top3 == HDR_ATTR);
    hdr_area  = (top3 == HDR_ATTR) ? AREA_ATTR : AREA_CHAR;
    hdr_row   = byte_i[ROW_W-1:0];
    col_burst = byte_i[TOP-1];
    col_num   = byte_i[COL_W-1:0];
  end

endmodule

// File: rtl/osd_seq_ctrl.sv
module osd_seq_ctrl
  import osd_wr_pkg::*;
#(
  parameter int ROW_W = 5,
  parameter int COL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_vld,
  input  logic             frm_mark,
  input  logic             top_set,
  input  logic             hdr_hit,
  input  area_e            hdr_area,
  input  logic [ROW_W-1:0] hdr_row,
  input  logic             col_burst,
  input  logic [COL_W-1:0] col_num,
  output logic             req_vld,
  output logic             req_burst,
  output area_e            req_area,
  output logic [ROW_W-1:0] req_row,
  output logic [COL_W-1:0] req_col
);

  localparam logic [COL_W-1:0] COL_LAST = {COL_W{1'b1}};
  localparam logic [ROW_W-1:0] ROW_ONE  = {{(ROW_W-1){1'b0}}, 1'b1};
  localparam logic [COL_W-1:0] COL_ONE  = {{(COL_W-1){1'b0}}, 1'b1};

  pstate_e          st_q, st_d;
  area_e            area_q, area_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic [COL_W-1:0] col_q, col_d;
  logic             step_en;

  // Next-state logic
  always_comb begin
    st_d    = st_q;
    area_d  = area_q;
    row_d   = row_q;
    col_d   = col_q;
    req_vld = 1'b0;
    if (frm_mark) begin
      st_d = ST_ROW;
    end else if (byte_vld) begin
      case (st_q)
        ST_ROW: begin
          if (hdr_hit) begin
            area_d = hdr_area;
            row_d  = hdr_row;
            st_d   = ST_COL;
          end
        end
        ST_COL, ST_NEXT: begin
          if (top_set) begin
            if (hdr_hit) begin
              area_d = hdr_area;
              row_d  = hdr_row;
              st_d   = ST_COL;
            end else begin
              st_d = ST_ROW;
            end
          end else begin
            col_d = col_num;
            st_d  = col_burst ? ST_BURST : ST_DATA;
          end
        end
        ST_DATA: begin
          req_vld = 1'b1;
          st_d    = ST_NEXT;
        end
        ST_BURST: begin
          req_vld = 1'b1;
          if (col_q == COL_LAST) begin
            col_d = '0;
            row_d = row_q + ROW_ONE;
          end else begin
            col_d = col_q + COL_ONE;
          end
        end
        default: st_d = ST_ROW;
      endcase
    end
  end

  assign step_en   = frm_mark | byte_vld;
  assign req_burst = (st_q == ST_BURST);
  assign req_area  = area_q;
  assign req_row   = row_q;
  assign req_col   = col_q;

  // State registers with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_ROW;
      area_q <= AREA_CHAR;
      row_q  <= '0;
      col_q  <= '0;
    end else if (step_en) begin
      st_q   <= st_d;
      area_q <= area_d;
      row_q  <= row_d;
      col_q  <= col_d;
    end
  end

endmodule

// File: rtl/osd_wr_gate.sv
module osd_wr_gate
  import osd_wr_pkg::*;
#(
  parameter int DATA_W          = 8,
  parameter int ROW_W           = 5,
  parameter int COL_W           = 5,
  parameter int CHAR_ROWS       = 15,
  parameter int CHAR_COLS       = 30,
  parameter int ATTR_ROWS       = 17,
  parameter int ATTR_BURST_COLS = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic              req_burst,
  input  area_e             req_area,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [DATA_W-1:0] req_data,
  output logic              wr_en,
  output logic              wr_area,
  output logic [ROW_W-1:0]  wr_row,
  output logic [COL_W-1:0]  wr_col,
  output logic [DATA_W-1:0] wr_data
);

  logic in_range;
  logic accept;

  always_comb begin
    if (req_area == AREA_CHAR) begin
      in_range = (int'(req_row) < CHAR_ROWS) && (int'(req_col) < CHAR_COLS);
    end else begin
      in_range = (int'(req_row) < ATTR_ROWS) &&
                 (!req_burst || (int'(req_col) < ATTR_BURST_COLS));
    end
    accept = req_vld && in_range;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en <= 1'b0;
    end else begin
      wr_en <= accept;
    end
  end

  // Fields load only on an accepted write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_area <= 1'b0;
      wr_row  <= '0;
      wr_col  <= '0;
      wr_data <= '0;
    end else if (accept) begin
      wr_area <= req_area;
      wr_row  <= req_row;
      wr_col  <= req_col;
      wr_data <= req_data;
    end
  end

endmodule

// File: rtl/osd_wr_parser.sv
module osd_wr_parser
  import osd_wr_pkg::*;
#(
  parameter int DATA_W          = 8,
  parameter int ROW_W           = 5,
  parameter int COL_W           = 5,
  parameter int CHAR_ROWS       = 15,
  parameter int CHAR_COLS       = 30,
  parameter int ATTR_ROWS       = 17,
  parameter int ATTR_BURST_COLS = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              frm_start,
  input  logic              frm_stop,
  output logic              wr_en,
  output logic              wr_area,
  output logic [ROW_W-1:0]  wr_row,
  output logic [COL_W-1:0]  wr_col,
  output logic [DATA_W-1:0] wr_data
);

  logic             top_set;
  logic             hdr_hit;
  area_e            hdr_area;
  logic [ROW_W-1:0] hdr_row;
  logic             col_burst;
  logic [COL_W-1:0] col_num;
  logic             frm_mark;
  logic             req_vld;
  logic             req_burst;
  area_e            req_area;
  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;

  assign frm_mark = frm_start | frm_stop;

  osd_byte_decode #(
    .DATA_W (DATA_W),
    .ROW_W  (ROW_W),
    .COL_W  (COL_W)
  ) u_dec (
    .byte_i    (byte_data),
    .top_set   (top_set),
    .hdr_hit   (hdr_hit),
    .hdr_area  (hdr_area),
    .hdr_row   (hdr_row),
    .col_burst (col_burst),
    .col_num   (col_num)
  );

  osd_seq_ctrl #(
    .ROW_W (ROW_W),
    .COL_W (COL_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_vld  (byte_vld),
    .frm_mark  (frm_mark),
    .top_set   (top_set),
    .hdr_hit   (hdr_hit),
    .hdr_area  (hdr_area),
    .hdr_row   (hdr_row),
    .col_burst (col_burst),
    .col_num   (col_num),
    .req_vld   (req_vld),
    .req_burst (req_burst),
    .req_area  (req_area),
    .req_row   (req_row),
    .req_col   (req_col)
  );

  osd_wr_gate #(
    .DATA_W          (DATA_W),
    .ROW_W           (ROW_W),
    .COL_W           (COL_W),
    .CHAR_ROWS       (CHAR_ROWS),
    .CHAR_COLS       (CHAR_COLS),
    .ATTR_ROWS       (ATTR_ROWS),
    .ATTR_BURST_COLS (ATTR_BURST_COLS)
  ) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_vld   (req_vld),
    .req_burst (req_burst),
    .req_area  (req_area),
    .req_row   (req_row),
    .req_col   (req_col),
    .req_data  (byte_data),
    .wr_en     (wr_en),
    .wr_area   (wr_area),
    .wr_row    (wr_row),
    .wr_col    (wr_col),
    .wr_data   (wr_data)
  );

endmodule

// File: rtl/osd_wr_parser_chk.sv
module osd_wr_parser_chk #(
  parameter int DATA_W    = 8,
  parameter int ROW_W     = 5,
  parameter int COL_W     = 5,
  parameter int CHAR_ROWS = 15,
  parameter int CHAR_COLS = 30,
  parameter int ATTR_ROWS = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              byte_vld,
  input logic [DATA_W-1:0] byte_data,
  input logic              frm_start,
  input logic              frm_stop,
  input logic              wr_en,
  input logic              wr_area,
  input logic [ROW_W-1:0]  wr_row,
  input logic [COL_W-1:0]  wr_col,
  input logic [DATA_W-1:0] wr_data
);

  AST_WR_FROM_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($past(byte_vld) && !$past(frm_start) && !$past(frm_stop))); // R12

  AST_DATA_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_data == $past(byte_data))); // R12

  AST_CHAR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_area) |-> ((int'(wr_row) < CHAR_ROWS) && (int'(wr_col) < CHAR_COLS))); // R11

  AST_ATTR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_area) |-> (int'(wr_row) < ATTR_ROWS)); // R11

  AST_MARK_THEN_HEADER: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (!$past(frm_start, 2) && !$past(frm_stop, 2))); // R10

endmodule

bind osd_wr_parser osd_wr_parser_chk #(
  .DATA_W    (DATA_W),
  .ROW_W     (ROW_W),
  .COL_W     (COL_W),
  .CHAR_ROWS (CHAR_ROWS),
  .CHAR_COLS (CHAR_COLS),
  .ATTR_ROWS (ATTR_ROWS)
) u_chk (.*);

// File: tb/osd_wr_parser_test.sv
`timescale 1ns/1ps
module osd_wr_parser_test;

  logic       clk;
  logic       rst_n;
  logic       byte_vld;
  logic [7:0] byte_data;
  logic       frm_start;
  logic       frm_stop;
  logic       wr_en;
  logic       wr_area;
  logic [4:0] wr_row;
  logic [4:0] wr_col;
  logic [7:0] wr_data;

  int n_chk;
  int n_fail;
  bit done;

  osd_wr_parser uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_vld  (byte_vld),
    .byte_data (byte_data),
    .frm_start (frm_start),
    .frm_stop  (frm_stop),
    .wr_en     (wr_en),
    .wr_area   (wr_area),
    .wr_row    (wr_row),
    .wr_col    (wr_col),
    .wr_data   (wr_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input logic ew, input logic ea, input int er, input int ec,
                       input logic [7:0] ed, input string tag);
    n_chk++;
    if (wr_en !== ew ||
        (ew && (wr_area !== ea || wr_row !== 5'(er) || wr_col !== 5'(ec) || wr_data !== ed))) begin
      n_fail++;
      $display("FAIL %s: got en=%0b area=%0b row=%0d col=%0d data=%02h, expected en=%0b area=%0b row=%0d col=%0d data=%02h",
               tag, wr_en, wr_area, wr_row, wr_col, wr_data, ew, ea, er, ec, ed);
    end
  endtask

  // Present one byte; the result is due one edge later
  task automatic put(input logic [7:0] b, input logic ew, input logic ea,
                     input int er, input int ec, input string tag);
    @(negedge clk);
    byte_vld  = 1'b1;
    byte_data = b;
    @(posedge clk);
    #1;
    byte_vld = 1'b0;
    check(ew, ea, er, ec, b, tag);
  endtask

  task automatic mark(input bit is_stop, input bit with_byte, input logic [7:0] b);
    @(negedge clk);
    if (is_stop) frm_stop = 1'b1; else frm_start = 1'b1;
    byte_vld  = with_byte;
    byte_data = b;
    @(posedge clk);
    #1;
    frm_start = 1'b0;
    frm_stop  = 1'b0;
    byte_vld  = 1'b0;
    check(1'b0, 1'b0, 0, 0, 8'h00, "R10 marker");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: got no completion, expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; byte_vld = 1'b0; byte_data = 8'h00;
    frm_start = 1'b0; frm_stop = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    n_chk++;
    if (wr_en !== 1'b0 || wr_area !== 1'b0 || wr_row !== 5'd0 || wr_col !== 5'd0 || wr_data !== 8'h00) begin
      n_fail++;
      $display("FAIL R1: got en=%0b row=%0d col=%0d data=%02h, expected all zero", wr_en, wr_row, wr_col, wr_data);
    end
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check(1'b0, 1'b0, 0, 0, 8'h00, "R1 after release");

    // R4 R11 R2: addressed sweep over every character row/column code
    mark(1'b0, 1'b0, 8'h00);
    for (int r = 0; r < 16; r++) begin
      for (int c = 0; c < 32; c++) begin
        d = 8'(r * 37 + c * 11 + 3);
        put(8'(8'h80 | r), 1'b0, 1'b0, 0, 0, "R2 char header");
        put(8'(c), 1'b0, 1'b0, 0, 0, "R3 column");
        put(d, (r < 15) && (c < 30), 1'b0, r, c, "R4 R11 char write");
      end
    end
    // Attribute sweep, rows 0..18
    for (int r = 0; r < 19; r++) begin
      for (int c = 0; c < 32; c++) begin
        d = 8'(r * 53 + c * 7 + 1);
        put(8'(8'hA0 | r), 1'b0, 1'b0, 0, 0, "R2 attr header");
        put(8'(c), 1'b0, 1'b0, 0, 0, "R3 column");
        put(d, (r < 17), 1'b1, r, c, "R4 R11 attr write");
      end
    end

    // R5 and format switching, ending in a burst
    mark(1'b0, 1'b0, 8'h00);
    put(8'h83, 1'b0, 1'b0, 0, 0, "R2");
    put(8'h05, 1'b0, 1'b0, 0, 0, "R3");
    put(8'h11, 1'b1, 1'b0, 3, 5, "R4");
    put(8'h07, 1'b0, 1'b0, 0, 0, "R5 column only");
    put(8'h22, 1'b1, 1'b0, 3, 7, "R5 same row");
    put(8'hA2, 1'b0, 1'b0, 0, 0, "R4 new row header");
    put(8'h01, 1'b0, 1'b0, 0, 0, "R3");
    put(8'h33, 1'b1, 1'b1, 2, 1, "R4 attr");
    put(8'h41, 1'b0, 1'b0, 0, 0, "R3 burst column");
    put(8'h44, 1'b1, 1'b1, 2, 1, "R6 burst first");
    put(8'h85, 1'b1, 1'b1, 2, 2, "R9 bit7 data");
    put(8'hA0, 1'b1, 1'b1, 2, 3, "R9 header-like data");

    // R2 ignored non-header, R3 re-read header
    mark(1'b0, 1'b0, 8'h00);
    put(8'hC3, 1'b0, 1'b0, 0, 0, "R2 ignored");
    put(8'h05, 1'b0, 1'b0, 0, 0, "R2 ignored");
    put(8'h81, 1'b0, 1'b0, 0, 0, "R2");
    put(8'hA4, 1'b0, 1'b0, 0, 0, "R3 header at column slot");
    put(8'h02, 1'b0, 1'b0, 0, 0, "R3");
    put(8'h66, 1'b1, 1'b1, 4, 2, "R3 reread header");

    // R10 marker handling
    put(8'h81, 1'b0, 1'b0, 0, 0, "R10 setup");
    put(8'h02, 1'b0, 1'b0, 0, 0, "R10 setup");
    mark(1'b1, 1'b0, 8'h00);
    put(8'h77, 1'b0, 1'b0, 0, 0, "R10 row expected");
    put(8'h84, 1'b0, 1'b0, 0, 0, "R10");
    put(8'h03, 1'b0, 1'b0, 0, 0, "R10");
    mark(1'b1, 1'b1, 8'h55);
    put(8'h55, 1'b0, 1'b0, 0, 0, "R10 dropped byte");
    put(8'h84, 1'b0, 1'b0, 0, 0, "R10");
    put(8'h03, 1'b0, 1'b0, 0, 0, "R10");
    put(8'h55, 1'b1, 1'b0, 4, 3, "R10 recovered");

    // Character burst from row 0 col 0 through row 15
    mark(1'b0, 1'b0, 8'h00);
    put(8'h80, 1'b0, 1'b0, 0, 0, "R6 setup");
    put(8'h40, 1'b0, 1'b0, 0, 0, "R6 setup");
    for (int r = 0; r < 16; r++) begin
      for (int c = 0; c < 32; c++) begin
        d = 8'(r * 29 + c * 5 + 9);
        put(d, (r < 15) && (c < 30), 1'b0, r, c, "R6 R7 char burst");
      end
    end
    // Attribute burst from row 0 col 0 through row 17
    mark(1'b0, 1'b0, 8'h00);
    put(8'hA0, 1'b0, 1'b0, 0, 0, "R8 setup");
    put(8'h40, 1'b0, 1'b0, 0, 0, "R8 setup");
    for (int r = 0; r < 18; r++) begin
      for (int c = 0; c < 32; c++) begin
        d = 8'(r * 41 + c * 3 + 17);
        put(d, (r < 17) && (c < 31), 1'b1, r, c, "R6 R8 attr burst");
      end
    end

    // R12: strobe lasts one cycle only
    @(posedge clk);
    #1;
    check(1'b0, 1'b0, 0, 0, 8'h00, "R12 single cycle");
    finish_run();
  end

endmodule